// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each received Ethernet frame, whether the frame is handed on to the application or discarded, judged on its destination address (DA) and source address (SA). An upstream parser presents the two 48-bit addresses together with a one-cycle frame strobe. A set of static control inputs selects the filtering policy: accept everything, promiscuous operation, broadcast blocking, blanket multicast acceptance, inverted DA or SA sense, SA-based dropping, and hash or exact matching.

Exact matching uses a small bank of address slots. Each slot has an enable bit and a flag that says whether it compares against the SA or the DA. Hash matching indexes a 64-bit table with six bits derived from the CRC-32 of the DA. One clock after the strobe the block presents a registered verdict and two status bits, DA-fail and SA-fail, for the receive status word.

Address byte order: `da_i[7:0]` and `sa_i[7:0]` hold the first byte on the wire, and within each byte bit 0 is sent first. Bit 0 of `da_i` is therefore the first transmitted bit.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_valid_o`, `pass_o`, `da_fail_o` and `sa_fail_o` are all 0.
- R2: `res_valid_o` is 1 exactly in the cycle after a cycle with `frm_valid_i` high. `pass_o`, `da_fail_o` and `sa_fail_o` change only at that point and otherwise hold their values.
- R3: A unicast DA passes exact matching only if it equals a slot that is enabled and has its SA flag clear. A disabled slot, or a slot flagged for SA, never matches a DA.
- R4: With `da_invert_i` set, the DA match result is inverted for unicast and multicast alike, so a matching DA fails and a non-matching DA passes.
- R5: A DA with `da_i[0]`=1 that is not all ones is multicast. With `mcast_all_i` set, every multicast DA passes the DA filter. Otherwise multicast follows the hash or exact rules.
- R6: For each frame type (unicast uses `hash_ucast_i`, multicast uses `hash_mcast_i`), a set hash bit selects the hash result alone, or hash OR exact match when `hash_or_exact_i` is set. A clear hash bit selects exact matching alone. The hash index is built from the complemented reflected CRC-32 (polynomial 0xEDB88320, preset all ones) taken over `da_i` bit 0 first. Its bit 0 becomes the index MSB and its bit 5 the index LSB. The index selects bit `hash_tbl_i[index]`.
- R7: An all-ones DA (broadcast) passes the DA filter. With `bcast_block_i` set, broadcast frames are dropped, and this overrides promiscuous and receive-all.
- R8: SA matching compares all 48 bits, including bit 47, against enabled slots flagged for SA. SA-fail is set on no match, or on a match when `sa_invert_i` is set.
- R9: With `sa_drop_i` set, a frame with SA-fail is dropped. With it clear, SA-fail only sets the status bit.
- R10: With `rx_all_i` set, a non-blocked frame passes, and DA-fail and SA-fail still report the filter results.
- R11: With `promisc_i` set, a non-blocked frame passes, and DA-fail and SA-fail are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid_i | input | 1 | One-cycle strobe: `da_i` and `sa_i` are valid |
| da_i | input | 48 | Destination address, first wire bit in bit 0 |
| sa_i | input | 48 | Source address, first wire bit in bit 0 |
| rx_all_i | input | 1 | Pass every frame, keep status |
| promisc_i | input | 1 | Pass every frame, clear status |
| bcast_block_i | input | 1 | Drop broadcast frames, top priority |
| mcast_all_i | input | 1 | Accept all multicast DAs |
| da_invert_i | input | 1 | Invert the DA match sense |
| sa_drop_i | input | 1 | Drop frames that fail the SA check |
| sa_invert_i | input | 1 | Invert the SA match sense |
| hash_or_exact_i | input | 1 | Accept on a hash hit or an exact hit |
| hash_ucast_i | input | 1 | Use the hash for unicast DAs |
| hash_mcast_i | input | 1 | Use the hash for multicast DAs |
| slot_addr_i | input | NUM_SLOTS*48 | Exact-match slot addresses, slot n at [n*48 +: 48] |
| slot_en_i | input | NUM_SLOTS | Slot enable bits |
| slot_is_sa_i | input | NUM_SLOTS | 1: slot compares the SA, 0: slot compares the DA |
| hash_tbl_i | input | 64 | Hash acceptance table |
| res_valid_o | output | 1 | Verdict valid, one cycle after the strobe |
| pass_o | output | 1 | 1: forward frame, 0: drop |
| da_fail_o | output | 1 | DA filter failed (status) |
| sa_fail_o | output | 1 | SA filter failed (status) |

## Verification
Broadcast blocking and the two accept-everything modes, promiscuous and receive-all, can all claim the same frame. A vector drives an all-ones DA with all three controls set together and expects a drop with both fail bits clear. SA rejection also coincides with a DA pass: frames are sent whose DA matches but whose SA differs only in bit 47. With `sa_drop_i` both set and clear, the bench expects DA-fail low, SA-fail high, and a verdict that follows `sa_drop_i`.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int MAC_W   = 48;
    localparam int HASH_W  = 6;
    localparam int HASH_N  = 1 << HASH_W;
    localparam int CRC_W   = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

    typedef struct packed {
        logic rx_all;
        logic promisc;
        logic bcast_block;
        logic mcast_all;
        logic da_invert;
        logic sa_drop;
        logic sa_invert;
        logic hash_or_exact;
        logic hash_ucast;
        logic hash_mcast;
    } rxaf_ctl_t;

    typedef struct packed {
        logic pass;
        logic da_fail;
        logic sa_fail;
    } rxaf_res_t;

    typedef struct packed {
        logic      valid;
        rxaf_res_t res;
    } rxaf_state_t;

endpackage

// File: rtl/rxaf_hash_index.sv
module rxaf_hash_index
    import rxaf_pkg::*;
(
    input  logic [MAC_W-1:0]  da_i,
    output logic [HASH_W-1:0] idx_o
);

    logic [CRC_W-1:0] crc_reg;
    logic [CRC_W-1:0] crc_fin;

    // Reflected serial CRC over the DA, first wire bit first.
    always_comb begin
        logic fb;
        crc_reg = '1;
        for (int b = 0; b < MAC_W; b++) begin
            fb      = crc_reg[0] ^ da_i[b];
            crc_reg = {1'b0, crc_reg[CRC_W-1:1]} ^ (fb ? CRC_POLY_REFL : '0);
        end
    end

    assign crc_fin = ~crc_reg;

    // Bit-reversed top bits of the conventional CRC.
    for (genvar k = 0; k < HASH_W; k++) begin : g_idx
        assign idx_o[HASH_W-1-k] = crc_fin[k];
    end

endmodule

// File: rtl/rxaf_slot_match.sv
module rxaf_slot_match
    import rxaf_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [MAC_W-1:0]           da_i,
    input  logic [MAC_W-1:0]           sa_i,
    input  logic [NUM_SLOTS*MAC_W-1:0] slot_addr_i,
    input  logic [NUM_SLOTS-1:0]       slot_en_i,
    input  logic [NUM_SLOTS-1:0]       slot_is_sa_i,
    output logic                       da_hit_o,
    output logic                       sa_hit_o
);

    logic [NUM_SLOTS-1:0] da_hits;
    logic [NUM_SLOTS-1:0] sa_hits;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [MAC_W-1:0] ref_addr;
        assign ref_addr   = slot_addr_i[s*MAC_W +: MAC_W];
        assign da_hits[s] = slot_en_i[s] & ~slot_is_sa_i[s] & (ref_addr == da_i);
        assign sa_hits[s] = slot_en_i[s] &  slot_is_sa_i[s] & (ref_addr == sa_i);
    end

    assign da_hit_o = |da_hits;
    assign sa_hit_o = |sa_hits;

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
(
    input  rxaf_ctl_t         ctl_i,
    input  logic [MAC_W-1:0]  da_i,
    input  logic              da_exact_i,
    input  logic              sa_exact_i,
    input  logic              hash_hit_i,
    output rxaf_res_t         res_o
);

    logic is_bcast;
    logic is_mcast;
    logic hash_sel;
    logic da_match;
    logic da_ok;
    logic sa_bad;
    logic filt_ok;

    always_comb begin
        is_bcast = &da_i;
        is_mcast = da_i[0] & ~is_bcast;
        hash_sel = is_mcast ? ctl_i.hash_mcast : ctl_i.hash_ucast;

        if (hash_sel) begin
            da_match = ctl_i.hash_or_exact ? (hash_hit_i | da_exact_i) : hash_hit_i;
        end else begin
            da_match = da_exact_i;
        end

        if (is_bcast) begin
            da_ok = 1'b1;
        end else if (is_mcast && ctl_i.mcast_all) begin
            da_ok = 1'b1;
        end else begin
            da_ok = da_match ^ ctl_i.da_invert;
        end

        sa_bad  = ctl_i.sa_invert ? sa_exact_i : ~sa_exact_i;
        filt_ok = da_ok & ~(ctl_i.sa_drop & sa_bad);

        res_o.da_fail = ~da_ok;
        res_o.sa_fail = sa_bad;
        res_o.pass    = filt_ok;

        if (ctl_i.promisc) begin
            res_o.da_fail = 1'b0;
            res_o.sa_fail = 1'b0;
            res_o.pass    = 1'b1;
        end else if (ctl_i.rx_all) begin
            res_o.pass    = 1'b1;
        end

        if (is_bcast && ctl_i.bcast_block) begin
            res_o.pass = 1'b0;
        end
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frm_valid_i,
    input  logic [47:0]                da_i,
    input  logic [47:0]                sa_i,
    input  logic                       rx_all_i,
    input  logic                       promisc_i,
    input  logic                       bcast_block_i,
    input  logic                       mcast_all_i,
    input  logic                       da_invert_i,
    input  logic                       sa_drop_i,
    input  logic                       sa_invert_i,
    input  logic                       hash_or_exact_i,
    input  logic                       hash_ucast_i,
    input  logic                       hash_mcast_i,
    input  logic [NUM_SLOTS*48-1:0]    slot_addr_i,
    input  logic [NUM_SLOTS-1:0]       slot_en_i,
    input  logic [NUM_SLOTS-1:0]       slot_is_sa_i,
    input  logic [63:0]                hash_tbl_i,
    output logic                       res_valid_o,
    output logic                       pass_o,
    output logic                       da_fail_o,
    output logic                       sa_fail_o
);

    rxaf_ctl_t         ctl;
    logic [HASH_W-1:0] hash_idx;
    logic              hash_hit;
    logic              da_exact;
    logic              sa_exact;
    rxaf_res_t         verdict;
    rxaf_state_t       st_d;
    rxaf_state_t       st_q;

    assign ctl = '{rx_all:        rx_all_i,
                   promisc:       promisc_i,
                   bcast_block:   bcast_block_i,
                   mcast_all:     mcast_all_i,
                   da_invert:     da_invert_i,
                   sa_drop:       sa_drop_i,
                   sa_invert:     sa_invert_i,
                   hash_or_exact: hash_or_exact_i,
                   hash_ucast:    hash_ucast_i,
                   hash_mcast:    hash_mcast_i};

    rxaf_hash_index u_hash (
        .da_i  (da_i),
        .idx_o (hash_idx)
    );

    assign hash_hit = hash_tbl_i[hash_idx];

    rxaf_slot_match #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .da_i         (da_i),
        .sa_i         (sa_i),
        .slot_addr_i  (slot_addr_i),
        .slot_en_i    (slot_en_i),
        .slot_is_sa_i (slot_is_sa_i),
        .da_hit_o     (da_exact),
        .sa_hit_o     (sa_exact)
    );

    rxaf_decide u_decide (
        .ctl_i      (ctl),
        .da_i       (da_i),
        .da_exact_i (da_exact),
        .sa_exact_i (sa_exact),
        .hash_hit_i (hash_hit),
        .res_o      (verdict)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = frm_valid_i;
        if (frm_valid_i) begin
            st_d.res = verdict;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.valid;
    assign pass_o      = st_q.res.pass;
    assign da_fail_o   = st_q.res.da_fail;
    assign sa_fail_o   = st_q.res.sa_fail;

    assert_strobe_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_i |=> res_valid_o);

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid_i |=> (!res_valid_o && $stable(pass_o) && $stable(da_fail_o) && $stable(sa_fail_o)));

    assert_bcast_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && bcast_block_i && (&da_i)) |=> !pass_o);

    assert_promisc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && promisc_i && !(bcast_block_i && (&da_i))) |=> (pass_o && !da_fail_o && !sa_fail_o));

    assert_rx_all_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && rx_all_i && !(bcast_block_i && (&da_i))) |=> pass_o);

    assert_sa_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && sa_drop_i && !rx_all_i && !promisc_i) |=> (!sa_fail_o || !pass_o));

    assert_dafail_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && !rx_all_i && !promisc_i) |=> (!da_fail_o || !pass_o));

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

    localparam int NS = 4;

    localparam logic [47:0] A0   = 48'h00AB_CDEF_1200;
    localparam logic [47:0] S1   = 48'h0000_1234_5678;
    localparam logic [47:0] SBAD = 48'h8000_1234_5678;
    localparam logic [47:0] M2   = 48'h0000_0000_0011;
    localparam logic [47:0] MX   = 48'h0000_0000_00F3;
    localparam logic [47:0] U3   = 48'h0000_0000_0066;
    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] HU   = 48'h0042_1357_9BD0;

    // control order {rx_all, promisc, bblk, mall, dainv, sadrop, sainv, hoe, huc, hmc}
    localparam logic [9:0] C_RA = 10'h200, C_PR = 10'h100, C_BB = 10'h080, C_MA = 10'h040,
                           C_DI = 10'h020, C_SD = 10'h010, C_SI = 10'h008, C_HE = 10'h004,
                           C_HU = 10'h002, C_HM = 10'h001;

    typedef struct packed {
        logic [47:0] da;
        logic [47:0] sa;
        logic [9:0]  ctl;
        logic        tbl_ones;
        logic [2:0]  exp;   // {pass, da_fail, sa_fail}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{A0,   S1,   10'h0,             1'b0, 3'b100, 8'd3},  // R3 exact DA hit
        '{U3,   S1,   10'h0,             1'b0, 3'b010, 8'd3},  // R3 disabled slot
        '{S1,   S1,   10'h0,             1'b0, 3'b010, 8'd3},  // R3 SA slot ignored for DA
        '{A0,   S1,   C_DI,              1'b0, 3'b010, 8'd4},  // R4 match inverted
        '{U3,   S1,   C_DI,              1'b0, 3'b100, 8'd4},  // R4 miss inverted
        '{M2,   S1,   10'h0,             1'b0, 3'b100, 8'd5},  // R5 exact multicast
        '{MX,   S1,   10'h0,             1'b0, 3'b010, 8'd5},  // R5 multicast miss
        '{MX,   S1,   C_MA,              1'b0, 3'b100, 8'd5},  // R5 pass all multicast
        '{MX,   S1,   C_HM,              1'b1, 3'b100, 8'd6},  // R6 hash multicast hit
        '{M2,   S1,   C_HM,              1'b0, 3'b010, 8'd6},  // R6 hash only, exact ignored
        '{M2,   S1,   C_HM|C_HE,         1'b0, 3'b100, 8'd6},  // R6 hash or exact
        '{A0,   S1,   C_HM,              1'b0, 3'b100, 8'd6},  // R6 unicast still exact
        '{A0,   S1,   C_HU,              1'b0, 3'b010, 8'd6},  // R6 unicast hash miss
        '{U3,   S1,   C_HU,              1'b1, 3'b100, 8'd6},  // R6 unicast hash hit
        '{MX,   S1,   C_HU,              1'b1, 3'b010, 8'd6},  // R6 multicast not on unicast hash
        '{BC,   S1,   10'h0,             1'b0, 3'b100, 8'd7},  // R7 broadcast passes
        '{BC,   S1,   C_DI,              1'b0, 3'b100, 8'd7},  // R7 broadcast not inverted
        '{BC,   S1,   C_BB,              1'b0, 3'b000, 8'd7},  // R7 blocked
        '{BC,   S1,   C_BB|C_PR|C_RA,    1'b0, 3'b000, 8'd7},  // R7 block beats promisc and rx_all
        '{A0,   SBAD, 10'h0,             1'b0, 3'b101, 8'd8},  // R8 bit 47 differs
        '{A0,   S1,   C_SI,              1'b0, 3'b101, 8'd8},  // R8 inverse SA match fails
        '{A0,   A0,   10'h0,             1'b0, 3'b101, 8'd8},  // R8 DA slot not used for SA
        '{A0,   SBAD, C_SD,              1'b0, 3'b001, 8'd9},  // R9 SA drop
        '{A0,   SBAD, C_SD|C_SI,         1'b0, 3'b100, 8'd9},  // R9 inverse miss passes
        '{U3,   SBAD, C_RA,              1'b0, 3'b111, 8'd10}, // R10 status kept
        '{U3,   SBAD, C_PR|C_SD,         1'b0, 3'b100, 8'd11}  // R11 status cleared
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frm_valid = 1'b0;
    logic [47:0]       da = '0, sa = '0;
    logic [9:0]        ctl = '0;
    logic [NS*48-1:0]  slot_addr;
    logic [NS-1:0]     slot_en, slot_is_sa;
    logic [63:0]       hash_tbl = '0;
    logic              res_valid, pass, da_fail, sa_fail;
    int                checks = 0;
    int                failures = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    // slot0 DA A0, slot1 SA S1, slot2 DA M2, slot3 DA U3 disabled
    assign slot_addr  = {U3, M2, S1, A0};
    assign slot_en    = 4'b0111;
    assign slot_is_sa = 4'b0010;

    rx_addr_filter #(.NUM_SLOTS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid), .da_i(da), .sa_i(sa),
        .rx_all_i(ctl[9]), .promisc_i(ctl[8]), .bcast_block_i(ctl[7]), .mcast_all_i(ctl[6]),
        .da_invert_i(ctl[5]), .sa_drop_i(ctl[4]), .sa_invert_i(ctl[3]),
        .hash_or_exact_i(ctl[2]), .hash_ucast_i(ctl[1]), .hash_mcast_i(ctl[0]),
        .slot_addr_i(slot_addr), .slot_en_i(slot_en), .slot_is_sa_i(slot_is_sa),
        .hash_tbl_i(hash_tbl), .res_valid_o(res_valid), .pass_o(pass),
        .da_fail_o(da_fail), .sa_fail_o(sa_fail));

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
        end
        c = ~c;
        return {c[0], c[1], c[2], c[3], c[4], c[5]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive one frame; sample the registered result at the next falling edge
    task automatic send(input logic [47:0] d, input logic [47:0] s, input logic [9:0] c,
                        input logic [63:0] tbl, input logic [2:0] exp, input string req);
        @(negedge clk);
        da = d; sa = s; ctl = c; hash_tbl = tbl; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        check({res_valid, pass, da_fail, sa_fail} == {1'b1, exp}, req,
              {res_valid, pass, da_fail, sa_fail}, {1'b1, exp});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({res_valid, pass, da_fail, sa_fail} == 4'b0, "R1", {res_valid, pass, da_fail, sa_fail}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check({res_valid, pass, da_fail, sa_fail} == 4'b0, "R1", {res_valid, pass, da_fail, sa_fail}, 4'b0);

        for (int v = 0; v < NV; v++) begin
            send(VECS[v].da, VECS[v].sa, VECS[v].ctl, VECS[v].tbl_ones ? '1 : '0,
                 VECS[v].exp, $sformatf("R%0d vec%0d", VECS[v].req, v));
        end

        // R2: verdict pulse lasts one cycle and results hold while idle
        send(A0, SBAD, 10'h0, '0, 3'b101, "R2");
        da = U3; sa = S1; ctl = C_PR;
        @(negedge clk);
        check({res_valid, pass, da_fail, sa_fail} == 4'b0101, "R2",
              {res_valid, pass, da_fail, sa_fail}, 4'b0101);
        repeat (3) @(negedge clk);
        check({res_valid, pass, da_fail, sa_fail} == 4'b0101, "R2",
              {res_valid, pass, da_fail, sa_fail}, 4'b0101);

        // R6 exact index: single table bit at the computed unicast and multicast index
        send(HU, S1, C_HU, 64'd1 << hidx(HU), 3'b100, "R6 index hit");
        send(HU, S1, C_HU, ~(64'd1 << hidx(HU)), 3'b010, "R6 index miss");
        send(MX, S1, C_HM, 64'd1 << hidx(MX), 3'b100, "R6 mcast index hit");
        send(MX, S1, C_HM, ~(64'd1 << hidx(MX)), 3'b010, "R6 mcast index miss");

        // back-to-back strobes, R2
        @(negedge clk);
        da = A0; sa = S1; ctl = 10'h0; frm_valid = 1'b1;
        @(negedge clk);
        check({res_valid, pass, da_fail} == 3'b110, "R2 b2b first", {1'b0, res_valid, pass, da_fail}, 4'b0110);
        da = U3;
        @(negedge clk);
        frm_valid = 1'b0;
        check({res_valid, pass, da_fail} == 3'b101, "R2 b2b second", {1'b0, res_valid, pass, da_fail}, 4'b0101);

        // reset mid-run, R1
        rst_n = 1'b0;
        @(negedge clk);
        check({res_valid, pass, da_fail, sa_fail} == 4'b0, "R1 re-reset", {res_valid, pass, da_fail, sa_fail}, 4'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule